// File: doc/BRIEF.md
# Three-Layer Priority Alpha Compositor

This block merges up to three picture layers into one output pixel per clock. Two graphics layers and one video layer sit over a constant background color. For each pixel coordinate presented at its input, every layer decides whether it covers that point. A layer covers a point only if it is enabled, has a non-zero priority, and the coordinate falls inside its rectangular screen window. The covering layers are then stacked by priority and blended bottom to top.

Graphics layers carry premultiplied color together with a raw alpha field. The format code of each graphics layer decides how that field becomes an 8-bit alpha, and formats without alpha are drawn opaque. The video layer is always opaque. The surrounding display pipeline supplies the pixel/line coordinate and the pixel each layer presents at that coordinate. Each result appears two clocks after its input with a matching valid strobe.

Top module: `layer_compositor`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `out_pix` is 0.
- R2: Each cycle with `pix_valid` high produces exactly one cycle of `out_valid` high two clocks later, carrying that pixel's result. No other cycle has `out_valid` high.
- R3: A layer's window covers a point when win_x <= x < win_x+win_w and win_y <= y < win_y+win_h. A width or height of 0 covers nothing.
- R4: A layer contributes to a pixel only if its `layer_en` bit is 1 and its priority is non-zero. Otherwise it has no effect on the output.
- R5: Covering layers stack so that a higher priority is on top. On equal priority, the lower layer index is on top. The layer indices are graphics 0 = 0, graphics 1 = 1 and video = 2.
- R6: Each 8-bit channel of a blend step is min(255, src + round(dst*(255-alpha)/255)). Here dst is the result beneath, and channels are R = [23:16], G = [15:8], B = [7:0].
- R7: A graphics word holds premultiplied color in [23:0] and an alpha field in [31:24]. Format code 7 uses [31:24] as alpha, code 6 repeats [31:28] twice, and code 5 repeats bit 31 eight times. Code 4 and every other code use alpha 255 and ignore the field.
- R8: Inside its window, the video layer is opaque and replaces everything beneath it.
- R9: A pixel covered by no layer takes `bg_color`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Coordinate and layer pixels are valid this cycle |
| pix_x | input | XW | Pixel column |
| pix_y | input | YW | Line number |
| bg_color | input | 24 | Background RGB |
| layer_en | input | 3 | Enable bit per layer (bit i = layer i) |
| layer_prio | input | 3*PW | Priority per layer, layer i at [i*PW +: PW] |
| win_x | input | 3*XW | Window left edge per layer |
| win_y | input | 3*YW | Window top edge per layer |
| win_w | input | 3*XW | Window width per layer |
| win_h | input | 3*YW | Window height per layer |
| gfx_fmt | input | 6 | Format code, graphics 0 at [2:0], graphics 1 at [5:3] |
| gfx0_pix | input | 32 | Graphics 0 word at this coordinate |
| gfx1_pix | input | 32 | Graphics 1 word at this coordinate |
| vid_pix | input | 24 | Video RGB at this coordinate |
| out_valid | output | 1 | Result valid |
| out_pix | output | 24 | Blended RGB |

## Verification
The hardest situation to reach is a set of layers with equal priorities and partly overlapping windows. Tie-breaking and coverage then interact, and a translucent layer may sit on top of an opaque one. Directed pixels probe the window edges one column and one line inside and outside, each alpha format, and saturation when alpha is zero. A back-to-back stream then draws a fresh random configuration for every pixel: enables, priorities, windows, formats and alpha values. This makes ties, partial coverage and stacked translucency common. Every result is compared through a queue against a model that walks priority levels bottom up.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int NUM_LAYERS = 3;
    localparam int NUM_GFX    = 2;
    localparam int FMT_W      = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB565   = 3'd4,
        FMT_ARGB1555 = 3'd5,
        FMT_ARGB4444 = 3'd6,
        FMT_ARGB8888 = 3'd7
    } gfx_fmt_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic       covered;
        logic [7:0] alpha;
        rgb_t       color;
    } layer_px_t;

    // Alpha field to 8-bit alpha; formats without alpha are opaque.
    function automatic logic [7:0] expand_alpha(logic [FMT_W-1:0] fmt, logic [7:0] a);
        case (fmt)
            FMT_ARGB8888: return a;
            FMT_ARGB4444: return {a[7:4], a[7:4]};
            FMT_ARGB1555: return {8{a[7]}};
            default:      return 8'hFF;
        endcase
    endfunction

    // Rounded division by 255 for products up to 255*255.
    function automatic logic [7:0] div255(logic [15:0] x);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, x} + 17'd128;
        u = t + {8'd0, t[16:8]};
        return u[15:8];
    endfunction

    function automatic logic [7:0] blend_ch(logic [7:0] src, logic [7:0] dst, logic [7:0] a);
        logic [15:0] prod;
        logic [8:0]  sum;
        prod = dst * (8'hFF - a);
        sum  = {1'b0, src} + {1'b0, div255(prod)};
        return sum[8] ? 8'hFF : sum[7:0];
    endfunction

    function automatic rgb_t blend_px(rgb_t src, rgb_t dst, logic [7:0] a);
        rgb_t o;
        o.r = blend_ch(src.r, dst.r, a);
        o.g = blend_ch(src.g, dst.g, a);
        o.b = blend_ch(src.b, dst.b, a);
        return o;
    endfunction

endpackage

// File: rtl/lc_layer_front.sv
module lc_layer_front
    import lc_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11,
    parameter int PW = 2
) (
    input  logic [XW-1:0]    pix_x,
    input  logic [YW-1:0]    pix_y,
    input  logic             en,
    input  logic [PW-1:0]    prio,
    input  logic [XW-1:0]    wx,
    input  logic [YW-1:0]    wy,
    input  logic [XW-1:0]    ww,
    input  logic [YW-1:0]    wh,
    input  logic [FMT_W-1:0] fmt,
    input  logic [31:0]      word,
    output layer_px_t        px
);
    logic [XW:0] x_end;
    logic [YW:0] y_end;
    logic        in_x;
    logic        in_y;

    always_comb begin
        x_end = {1'b0, wx} + {1'b0, ww};
        y_end = {1'b0, wy} + {1'b0, wh};
        in_x  = ({1'b0, pix_x} >= {1'b0, wx}) && ({1'b0, pix_x} < x_end);
        in_y  = ({1'b0, pix_y} >= {1'b0, wy}) && ({1'b0, pix_y} < y_end);
        px.covered = en && (prio != '0) && in_x && in_y;
        px.alpha   = expand_alpha(fmt, word[31:24]);
        px.color   = rgb_t'(word[23:0]);
    end
endmodule

// File: rtl/lc_order.sv
module lc_order #(
    parameter int NL = 3,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] prio [NL],
    output logic [NL-1:0] sel  [NL]
);
    localparam int CW = $clog2(NL + 1);

    logic [CW-1:0] pos [NL];

    // pos[i] = number of layers stacked beneath layer i
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            pos[i] = '0;
            for (int j = 0; j < NL; j++) begin
                if (j != i) begin
                    if ((prio[j] < prio[i]) || ((prio[j] == prio[i]) && (j > i)))
                        pos[i] = pos[i] + CW'(1);
                end
            end
        end
        for (int s = 0; s < NL; s++)
            for (int i = 0; i < NL; i++)
                sel[s][i] = (pos[i] == CW'(s));
    end

    generate
        for (genvar s = 0; s < NL; s++) begin : g_chk
            // R5: every stacking slot is filled by exactly one layer
            p_slot_onehot_r5: assert property (@(posedge clk) disable iff (rst)
                $countones(sel[s]) == 1);
        end
    endgenerate
endmodule

// File: rtl/lc_blend_chain.sv
module lc_blend_chain
    import lc_pkg::*;
#(
    parameter int NL = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  rgb_t      bg,
    input  layer_px_t slot [NL],
    output rgb_t      mix
);
    rgb_t acc [NL+1];

    assign acc[0] = bg;

    generate
        for (genvar s = 0; s < NL; s++) begin : g_stage
            always_comb begin
                if (slot[s].covered)
                    acc[s+1] = blend_px(slot[s].color, acc[s], slot[s].alpha);
                else
                    acc[s+1] = acc[s];
            end

            // R6: a blend step never darkens below its own source color
            p_src_floor_r6: assert property (@(posedge clk) disable iff (rst)
                slot[s].covered |-> (acc[s+1].r >= slot[s].color.r) &&
                                    (acc[s+1].g >= slot[s].color.g) &&
                                    (acc[s+1].b >= slot[s].color.b));

            // R8: an opaque layer fully replaces what lies beneath it
            p_opaque_replace_r8: assert property (@(posedge clk) disable iff (rst)
                (slot[s].covered && slot[s].alpha == 8'hFF) |-> acc[s+1] == slot[s].color);
        end
    endgenerate

    assign mix = acc[NL];
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
    import lc_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11,
    parameter int PW = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pix_valid,
    input  logic [XW-1:0]              pix_x,
    input  logic [YW-1:0]              pix_y,
    input  logic [23:0]                bg_color,
    input  logic [NUM_LAYERS-1:0]      layer_en,
    input  logic [NUM_LAYERS*PW-1:0]   layer_prio,
    input  logic [NUM_LAYERS*XW-1:0]   win_x,
    input  logic [NUM_LAYERS*YW-1:0]   win_y,
    input  logic [NUM_LAYERS*XW-1:0]   win_w,
    input  logic [NUM_LAYERS*YW-1:0]   win_h,
    input  logic [NUM_GFX*FMT_W-1:0]   gfx_fmt,
    input  logic [31:0]                gfx0_pix,
    input  logic [31:0]                gfx1_pix,
    input  logic [23:0]                vid_pix,
    output logic                       out_valid,
    output logic [23:0]                out_pix
);
    localparam int NL  = NUM_LAYERS;
    localparam int VID = NL - 1;

    logic [31:0]      word_a [NL];
    logic [FMT_W-1:0] fmt_a  [NL];
    logic [PW-1:0]    prio_a [NL];
    layer_px_t        front  [NL];
    logic [NL-1:0]    sel    [NL];
    layer_px_t        slot_nx[NL];

    logic             s1_valid;
    rgb_t             s1_bg;
    layer_px_t        s1_slot[NL];
    rgb_t             mix;
    logic             s1_any;

    always_comb begin
        word_a[0]   = gfx0_pix;
        word_a[1]   = gfx1_pix;
        word_a[VID] = {8'h00, vid_pix};
        fmt_a[0]    = gfx_fmt[FMT_W-1:0];
        fmt_a[1]    = gfx_fmt[2*FMT_W-1:FMT_W];
        fmt_a[VID]  = FMT_RGB565;
    end

    generate
        for (genvar i = 0; i < NL; i++) begin : g_layer
            assign prio_a[i] = layer_prio[i*PW +: PW];
            lc_layer_front #(.XW(XW), .YW(YW), .PW(PW)) u_front (
                .pix_x (pix_x),
                .pix_y (pix_y),
                .en    (layer_en[i]),
                .prio  (prio_a[i]),
                .wx    (win_x[i*XW +: XW]),
                .wy    (win_y[i*YW +: YW]),
                .ww    (win_w[i*XW +: XW]),
                .wh    (win_h[i*YW +: YW]),
                .fmt   (fmt_a[i]),
                .word  (word_a[i]),
                .px    (front[i])
            );
        end
    endgenerate

    lc_order #(.NL(NL), .PW(PW)) u_order (
        .clk  (clk),
        .rst  (rst),
        .prio (prio_a),
        .sel  (sel)
    );

    // Route each layer into its stacking slot (slot 0 = bottom)
    always_comb begin
        for (int s = 0; s < NL; s++) begin
            slot_nx[s] = '0;
            for (int i = 0; i < NL; i++)
                if (sel[s][i]) slot_nx[s] = front[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_bg    <= '0;
            for (int s = 0; s < NL; s++) s1_slot[s] <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_bg    <= rgb_t'(bg_color);
            for (int s = 0; s < NL; s++) s1_slot[s] <= slot_nx[s];
        end
    end

    lc_blend_chain #(.NL(NL)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .bg   (s1_bg),
        .slot (s1_slot),
        .mix  (mix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pix   <= mix;
        end
    end

    always_comb begin
        s1_any = 1'b0;
        for (int s = 0; s < NL; s++) s1_any = s1_any | s1_slot[s].covered;
    end

    // R1: outputs are cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pix == '0));

    // R2: a result is only flagged for a pixel accepted the cycle before
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s1_valid));

    // R9: an uncovered pixel yields the background color
    p_bg_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_any) |=> out_pix == $past(s1_bg));
endmodule

// File: tb/layer_compositor_bench.sv
module layer_compositor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 11;
    localparam int YW = 11;
    localparam int PW = 2;
    localparam int NL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                pix_valid = 1'b0;
    logic [XW-1:0]       pix_x = '0;
    logic [YW-1:0]       pix_y = '0;
    logic [23:0]         bg = 24'h102030;
    logic [NL-1:0]       en = '0;
    int                  prio [NL];
    int                  wx [NL], wy [NL], ww [NL], wh [NL];
    int                  fmt [2];
    logic [31:0]         g0 = '0, g1 = '0;
    logic [23:0]         vid = '0;

    logic [NL*PW-1:0]    prio_p;
    logic [NL*XW-1:0]    wx_p, ww_p;
    logic [NL*YW-1:0]    wy_p, wh_p;
    logic [5:0]          fmt_p;
    logic                out_valid;
    logic [23:0]         out_pix;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            prio_p[i*PW +: PW] = PW'(prio[i]);
            wx_p[i*XW +: XW]   = XW'(wx[i]);
            ww_p[i*XW +: XW]   = XW'(ww[i]);
            wy_p[i*YW +: YW]   = YW'(wy[i]);
            wh_p[i*YW +: YW]   = YW'(wh[i]);
        end
        fmt_p = {3'(fmt[1]), 3'(fmt[0])};
    end

    layer_compositor #(.XW(XW), .YW(YW), .PW(PW)) u_layer_compositor (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .bg_color(bg), .layer_en(en), .layer_prio(prio_p),
        .win_x(wx_p), .win_y(wy_p), .win_w(ww_p), .win_h(wh_p),
        .gfx_fmt(fmt_p), .gfx0_pix(g0), .gfx1_pix(g1), .vid_pix(vid),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [7:0] alpha_of(int f, logic [31:0] w);
        if (f == 7) return w[31:24];
        if (f == 6) return 8'(w[31:28] * 17);
        if (f == 5) return w[31] ? 8'd255 : 8'd0;
        return 8'd255;
    endfunction

    function automatic logic [7:0] bch(int s, int d, int a);
        int v;
        v = s + (d * (255 - a) + 127) / 255;
        return (v > 255) ? 8'd255 : 8'(v);
    endfunction

    function automatic logic [23:0] model(int x, int y);
        logic [23:0] acc;
        logic [23:0] c;
        int a;
        acc = bg;
        for (int p = 1; p < (1 << PW); p++) begin
            for (int i = NL - 1; i >= 0; i--) begin
                if (en[i] && prio[i] == p && x >= wx[i] && x < wx[i] + ww[i] &&
                    y >= wy[i] && y < wy[i] + wh[i]) begin
                    if (i == 2) begin c = vid; a = 255; end
                    else if (i == 1) begin c = g1[23:0]; a = int'(alpha_of(fmt[1], g1)); end
                    else begin c = g0[23:0]; a = int'(alpha_of(fmt[0], g0)); end
                    acc = {bch(c[23:16], acc[23:16], a), bch(c[15:8], acc[15:8], a),
                           bch(c[7:0], acc[7:0], a)};
                end
            end
        end
        return acc;
    endfunction

    task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // Single pixel, then one idle cycle; checks no early result (R2)
    task automatic drive(int x, int y, string tag);
        @(negedge clk);
        pix_x = XW'(x); pix_y = YW'(y); pix_valid = 1'b1;
        exp_q.push_back(model(x, y));
        tag_q.push_back(tag);
        @(negedge clk);
        pix_valid = 1'b0;
        check(out_valid == 1'b0, "R2 early valid", {23'd0, out_valid}, 24'd0);
    endtask

    // Monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", out_pix, 24'd0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_pix == e, t, out_pix, e);
            end
        end
    end

    task automatic full_window(int i);
        wx[i] = 0; wy[i] = 0; ww[i] = 2047; wh[i] = 2047;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            prio[i] = 0; wx[i] = 0; wy[i] = 0; ww[i] = 0; wh[i] = 0;
        end
        fmt[0] = 4; fmt[1] = 4;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_pix == 24'd0, "R1 reset state", out_pix, 24'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_pix == 24'd0, "R1 after reset", out_pix, 24'd0);

        // R9: nothing enabled
        drive(5, 5, "R9 background");

        // R4: enabled with priority 0, then disabled with priority
        full_window(0); g0 = 32'h00AABBCC; fmt[0] = 4;
        en = 3'b001; prio[0] = 0;
        drive(7, 7, "R4 zero priority ignored");
        en = 3'b000; prio[0] = 2;
        drive(7, 7, "R4 disabled ignored");
        en = 3'b001;
        drive(7, 7, "R4 enabled drawn");
        en = 3'b000;

        // R3/R8: video window edges
        en = 3'b100; prio[2] = 1; vid = 24'h445566;
        wx[2] = 10; ww[2] = 4; wy[2] = 20; wh[2] = 2;
        drive(9, 20, "R3 left outside");
        drive(10, 20, "R3 left edge inside R8");
        drive(13, 21, "R3 bottom-right inside");
        drive(14, 20, "R3 right outside");
        drive(10, 22, "R3 bottom outside");
        drive(10, 19, "R3 top outside");
        ww[2] = 0;
        drive(10, 20, "R3 zero width");
        ww[2] = 4;

        // R6/R7: graphics 0 over video
        full_window(2); en = 3'b101; prio[0] = 2; prio[2] = 1;
        fmt[0] = 7; g0 = 32'h80402010;
        drive(1, 1, "R7 fmt7 R6 blend");
        fmt[0] = 6; g0 = 32'h3F102030;
        drive(1, 1, "R7 fmt6 nibble repeat");
        fmt[0] = 5; g0 = 32'h7FF0F0F0;
        drive(1, 1, "R7 fmt5 alpha0 R6 saturate");
        fmt[0] = 5; g0 = 32'h80123456;
        drive(1, 1, "R7 fmt5 alpha255");
        fmt[0] = 4; g0 = 32'h00ABCDEF;
        drive(1, 1, "R7 fmt4 opaque");
        fmt[0] = 1; g0 = 32'h00ABCDEF;
        drive(1, 1, "R7 other code opaque");

        // R5: ordering
        full_window(1); fmt[0] = 4; fmt[1] = 4;
        g0 = 32'h00111111; g1 = 32'h00222222; vid = 24'h333333;
        en = 3'b011; prio[0] = 2; prio[1] = 2;
        drive(3, 3, "R5 tie gfx0 on top");
        prio[1] = 3;
        drive(3, 3, "R5 gfx1 higher");
        en = 3'b111; prio[0] = 1; prio[1] = 1; prio[2] = 3;
        drive(3, 3, "R5 video on top R8");
        prio[2] = 1;
        drive(3, 3, "R5 all tie gfx0 on top");
        fmt[0] = 7; g0 = 32'h40101010; fmt[1] = 6; g1 = 32'h80202020; prio[1] = 2;
        drive(3, 3, "R5 R6 stacked translucency");

        // R2/R6: back-to-back random stream
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            for (int i = 0; i < NL; i++) begin
                prio[i] = int'($urandom_range(0, 3));
                wx[i] = int'($urandom_range(0, 6)); ww[i] = int'($urandom_range(0, 6));
                wy[i] = int'($urandom_range(0, 6)); wh[i] = int'($urandom_range(0, 6));
            end
            en = 3'($urandom);
            fmt[0] = int'($urandom_range(3, 7)); fmt[1] = int'($urandom_range(3, 7));
            g0 = $urandom; g1 = $urandom; vid = 24'($urandom); bg = 24'($urandom);
            pix_x = XW'($urandom_range(0, 10)); pix_y = YW'($urandom_range(0, 10));
            pix_valid = 1'b1;
            exp_q.push_back(model(int'(pix_x), int'(pix_y)));
            tag_q.push_back("R5 R6 random stream");
        end
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered",
              24'(exp_q.size()), 24'd0);
        check(out_valid == 1'b0, "R2 idle after stream", {23'd0, out_valid}, 24'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule